// File: doc/BRIEF.md
# Prescaled Timer with Compare-Match Output

This block is an 8-bit timer/counter. Its tick rate comes from a clock-select prescaler. One compare unit acts on an output pin whenever the count matches a programmed value. The count runs in one of two non-PWM shapes: it either wraps freely from its top value back to zero, or it returns to zero on the tick after it reaches the compare value. On each match the compare unit can toggle, clear or set an output register. While its action field is non-zero, that register replaces the general-purpose port value on the pin. The pin output-enable always follows a separate direction-enable control.

The timer side runs from one of two clocks, chosen by a source-select input that is changed only during reset. The choices are the system clock and a separate asynchronous input intended for a slow real-time oscillator. Control levels are supplied in the system-clock domain and cross into the timer domain through a synchronizer chain. A one-cycle prescaler-reset strobe crosses as a toggle, so it cannot be lost when the timer clock is slower. Reset is synchronous to whichever clock is active. Software can clear the prescaler so that the next divided tick arrives after a full, known interval.

Top module: `prescaled_cmp_timer`

## Requirements
- R1: While reset is held and after its release, `count_o` is 0, the compare register is 0, every synchronized control is 0 (timer stopped), and `pin_out` equals `port_val`.
- R2: `clk_sel` encodes 000 = stopped, 001 = a tick on every timer clock, and 010, 011, 100, 101, 110, 111 = one tick every 8, 32, 64, 128, 256, 1024 timer clocks. The count changes only on a tick.
- R3: A strobe on `psc_reset` sampled at system edge k leaves the prescaler at zero after edge k+3. The next divided tick then comes exactly N timer clocks later.
- R4: With `ctc_mode` = 0, a tick at count 255 gives count 0. Any other tick adds one.
- R5: With `ctc_mode` = 1, a tick taken while the count equals `cmp_val` returns the count to 0.
- R6: A match is a tick taken while the count equals `cmp_val`. On a match, `cmp_mode` 01 inverts the compare register, 10 clears it and 11 sets it, all at that same edge.
- R7: With `cmp_mode` 00 the compare register holds its value and `pin_out` follows `port_val`.
- R8: With `cmp_mode` non-zero, `pin_out` shows the compare register. `pin_oe` equals `dir_en` in every mode.
- R9: A change on `clk_sel`, `ctc_mode`, `cmp_mode` or `cmp_val` first acts on the third timer edge after it is presented.
- R10: With `use_async` = 1, the counter and prescaler advance on `async_clk` edges. With undivided select, N such edges add N to the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock; control interface domain |
| async_clk | input | 1 | Alternative asynchronous timer clock |
| use_async | input | 1 | 1 selects `async_clk` as the timer clock (change only in reset) |
| rst | input | 1 | Reset, active high, synchronous to each clock |
| clk_sel | input | 3 | Prescaler select |
| ctc_mode | input | 1 | 1 = clear-on-compare, 0 = free wrap |
| cmp_mode | input | 2 | Compare action: 00 off, 01 toggle, 10 clear, 11 set |
| cmp_val | input | 8 | Compare value |
| dir_en | input | 1 | Pin direction enable |
| psc_reset | input | 1 | One-cycle prescaler clear strobe |
| port_val | input | 1 | General-purpose port value |
| count_o | output | 8 | Current count |
| pin_out | output | 1 | Pin value |
| pin_oe | output | 1 | Pin output enable |

## Verification
Control levels take effect at the third timer edge after they are applied, and a prescaler strobe clears at the fourth. A count or compare-register change made at edge t is visible from the half-cycle that follows it. The bench keeps a cycle model with the same two-stage and three-stage delays on its own copies of the inputs. It drives and compares only on falling system edges, so every comparison falls half a period after the edge whose result it inspects. In the asynchronous phase, the bench counts falling edges of `async_clk` once the controls have settled and checks the change in the count over that window.

// File: rtl/tct_pkg.sv
package tct_pkg;

   typedef enum logic [1:0] {
      CMP_OFF    = 2'b00,
      CMP_TOGGLE = 2'b01,
      CMP_CLEAR  = 2'b10,
      CMP_SET    = 2'b11
   } cmp_act_e;

   localparam int unsigned SEL_W        = 3;
   localparam int unsigned MAX_TAP_SHIFT = 10;

   // log2 of the division ratio for each divided selection
   function automatic int unsigned tap_shift(input logic [SEL_W-1:0] sel);
      case (sel)
         3'd2:    return 3;
         3'd3:    return 5;
         3'd4:    return 6;
         3'd5:    return 7;
         3'd6:    return 8;
         3'd7:    return 10;
         default: return 0;
      endcase
   endfunction

endpackage

// File: rtl/tc_sync.sv
module tc_sync #(
   parameter int unsigned W      = 1,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stg [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (rst) stg[i] <= '0;
            else     stg[i] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (rst) stg[i] <= '0;
            else     stg[i] <= stg[i-1];
         end
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/tc_pulse_xfer.sv
module tc_pulse_xfer #(
   parameter int unsigned STAGES = 2
) (
   input  logic src_clk,
   input  logic dst_clk,
   input  logic rst,
   input  logic pulse_in,
   output logic pulse_out
);
   logic tog_src;
   logic tog_dst;
   logic tog_seen;

   always_ff @(posedge src_clk) begin
      if (rst)           tog_src <= 1'b0;
      else if (pulse_in) tog_src <= ~tog_src;
   end

   tc_sync #(.W(1), .STAGES(STAGES)) u_tog_sync (
      .clk (dst_clk),
      .rst (rst),
      .d   (tog_src),
      .q   (tog_dst)
   );

   always_ff @(posedge dst_clk) begin
      if (rst) tog_seen <= 1'b0;
      else     tog_seen <= tog_dst;
   end

   assign pulse_out = tog_dst ^ tog_seen;
endmodule

// File: rtl/tc_prescaler.sv
module tc_prescaler
   import tct_pkg::*;
#(
   parameter int unsigned PSC_W = 10
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             clr,
   input  logic [SEL_W-1:0] sel,
   output logic             tick,
   output logic [PSC_W-1:0] psc_val
);
   logic [PSC_W-1:0] psc;
   logic [PSC_W-1:0] mask;
   logic             raw_tick;

   if (PSC_W < MAX_TAP_SHIFT) begin : g_bad_width
      $error("tc_prescaler: PSC_W must cover the largest division tap");
   end

   always_ff @(posedge clk) begin
      if (rst || clr) psc <= '0;
      else            psc <= psc + 1'b1;
   end

   always_comb begin
      mask = PSC_W'((32'd1 << tap_shift(sel)) - 32'd1);
      case (sel)
         3'd0:    raw_tick = 1'b0;
         3'd1:    raw_tick = 1'b1;
         default: raw_tick = ((psc & mask) == mask);
      endcase
   end

   assign tick    = raw_tick & ~clr;
   assign psc_val = psc;
endmodule

// File: rtl/tc_counter_cmp.sv
module tc_counter_cmp
   import tct_pkg::*;
#(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             tick,
   input  logic             ctc,
   input  cmp_act_e         act,
   input  logic [CNT_W-1:0] cmp,
   output logic [CNT_W-1:0] cnt,
   output logic             oc
);
   logic match;

   assign match = tick && (cnt == cmp);

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt <= '0;
      end else if (tick) begin
         if (ctc && match) cnt <= '0;
         else              cnt <= cnt + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         oc <= 1'b0;
      end else if (match) begin
         case (act)
            CMP_TOGGLE: oc <= ~oc;
            CMP_CLEAR:  oc <= 1'b0;
            CMP_SET:    oc <= 1'b1;
            default:    oc <= oc;
         endcase
      end
   end
endmodule

// File: rtl/prescaled_cmp_timer.sv
module prescaled_cmp_timer
   import tct_pkg::*;
#(
   parameter int unsigned CNT_W       = 8,
   parameter int unsigned PSC_W       = 10,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             sys_clk,
   input  logic             async_clk,
   input  logic             use_async,
   input  logic             rst,
   input  logic [2:0]       clk_sel,
   input  logic             ctc_mode,
   input  logic [1:0]       cmp_mode,
   input  logic [CNT_W-1:0] cmp_val,
   input  logic             dir_en,
   input  logic             psc_reset,
   input  logic             port_val,
   output logic [CNT_W-1:0] count_o,
   output logic             pin_out,
   output logic             pin_oe
);
   localparam int unsigned CTL_W = SEL_W + 1 + 2 + CNT_W;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("prescaled_cmp_timer: SYNC_STAGES must be at least 2");
   end
   if (CNT_W < 2) begin : g_bad_cnt
      $error("prescaled_cmp_timer: CNT_W must be at least 2");
   end

   logic             tmr_clk;
   logic [CTL_W-1:0] ctl_raw;
   logic [CTL_W-1:0] ctl_s;
   logic [SEL_W-1:0] sel_s;
   logic             ctc_s;
   cmp_act_e         act_s;
   logic [CNT_W-1:0] cmp_s;
   logic             psc_clr;
   logic             tick;
   logic [PSC_W-1:0] psc_val;
   logic             oc;

   assign tmr_clk = use_async ? async_clk : sys_clk;

   assign ctl_raw = {clk_sel, ctc_mode, cmp_mode, cmp_val};

   tc_sync #(.W(CTL_W), .STAGES(SYNC_STAGES)) u_ctl_sync (
      .clk (tmr_clk),
      .rst (rst),
      .d   (ctl_raw),
      .q   (ctl_s)
   );

   assign sel_s = ctl_s[CTL_W-1 -: SEL_W];
   assign ctc_s = ctl_s[CNT_W+2];
   assign act_s = cmp_act_e'(ctl_s[CNT_W+1 -: 2]);
   assign cmp_s = ctl_s[CNT_W-1:0];

   tc_pulse_xfer #(.STAGES(SYNC_STAGES)) u_psr_xfer (
      .src_clk   (sys_clk),
      .dst_clk   (tmr_clk),
      .rst       (rst),
      .pulse_in  (psc_reset),
      .pulse_out (psc_clr)
   );

   tc_prescaler #(.PSC_W(PSC_W)) u_psc (
      .clk     (tmr_clk),
      .rst     (rst),
      .clr     (psc_clr),
      .sel     (sel_s),
      .tick    (tick),
      .psc_val (psc_val)
   );

   tc_counter_cmp #(.CNT_W(CNT_W)) u_cnt (
      .clk  (tmr_clk),
      .rst  (rst),
      .tick (tick),
      .ctc  (ctc_s),
      .act  (act_s),
      .cmp  (cmp_s),
      .cnt  (count_o),
      .oc   (oc)
   );

   assign pin_out = (act_s != CMP_OFF) ? oc : port_val;
   assign pin_oe  = dir_en;
endmodule

// File: rtl/prescaled_cmp_timer_chk.sv
module prescaled_cmp_timer_chk
   import tct_pkg::*;
#(
   parameter int unsigned CNT_W = 8,
   parameter int unsigned PSC_W = 10
) (
   input logic             clk,
   input logic             rst,
   input logic             tick,
   input logic             ctc,
   input cmp_act_e         act,
   input logic [CNT_W-1:0] cmp,
   input logic [CNT_W-1:0] cnt,
   input logic             oc,
   input logic             psc_clr,
   input logic [PSC_W-1:0] psc_val
);
   // R2
   idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !tick |=> $stable(cnt));

   // R3
   psc_clear_chk: assert property (@(posedge clk) disable iff (rst)
      psc_clr |=> (psc_val == '0));

   // R4
   free_wrap_chk: assert property (@(posedge clk) disable iff (rst)
      (tick && !ctc && (cnt == {CNT_W{1'b1}})) |=> (cnt == '0));

   // R5
   ctc_return_chk: assert property (@(posedge clk) disable iff (rst)
      (tick && ctc && (cnt == cmp)) |=> (cnt == '0));

   // R6
   toggle_act_chk: assert property (@(posedge clk) disable iff (rst)
      (tick && (cnt == cmp) && (act == CMP_TOGGLE)) |=> (oc != $past(oc)));

   // R6
   set_act_chk: assert property (@(posedge clk) disable iff (rst)
      (tick && (cnt == cmp) && (act == CMP_SET)) |=> oc);

   // R6
   clear_act_chk: assert property (@(posedge clk) disable iff (rst)
      (tick && (cnt == cmp) && (act == CMP_CLEAR)) |=> !oc);

   // R7
   off_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (act == CMP_OFF) |=> $stable(oc));
endmodule

bind prescaled_cmp_timer prescaled_cmp_timer_chk #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_chk (
   .clk     (tmr_clk),
   .rst     (rst),
   .tick    (tick),
   .ctc     (ctc_s),
   .act     (act_s),
   .cmp     (cmp_s),
   .cnt     (count_o),
   .oc      (oc),
   .psc_clr (psc_clr),
   .psc_val (psc_val)
);

// File: tb/prescaled_cmp_timer_test.sv
module prescaled_cmp_timer_test;
   localparam int CLK_PERIOD   = 10;
   localparam int ASYNC_PERIOD = 37;

   logic       sys_clk = 1'b0;
   logic       async_clk = 1'b0;
   logic       use_async = 1'b0;
   logic       rst = 1'b1;
   logic [2:0] clk_sel = '0;
   logic       ctc_mode = 1'b0;
   logic [1:0] cmp_mode = '0;
   logic [7:0] cmp_val = '0;
   logic       dir_en = 1'b0;
   logic       psc_reset = 1'b0;
   logic       port_val = 1'b0;
   logic [7:0] count_o;
   logic       pin_out;
   logic       pin_oe;

   int n_cmp = 0;
   int n_bad = 0;
   bit async_phase = 1'b0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2)   sys_clk   = ~sys_clk;
   always #(ASYNC_PERIOD/2) async_clk = ~async_clk;

   prescaled_cmp_timer uut (
      .sys_clk(sys_clk), .async_clk(async_clk), .use_async(use_async), .rst(rst),
      .clk_sel(clk_sel), .ctc_mode(ctc_mode), .cmp_mode(cmp_mode), .cmp_val(cmp_val),
      .dir_en(dir_en), .psc_reset(psc_reset), .port_val(port_val),
      .count_o(count_o), .pin_out(pin_out), .pin_oe(pin_oe)
   );

   // ---------------- reference model (system-clock phase) ----------------
   logic [13:0] m_p1, m_p2;
   logic        m_t1, m_t2, m_t3;
   logic [9:0]  m_psc;
   logic [7:0]  m_cnt;
   logic        m_oc;

   function automatic int divisor(input logic [2:0] cs);
      case (cs)
         3'd1: return 1;
         3'd2: return 8;
         3'd3: return 32;
         3'd4: return 64;
         3'd5: return 128;
         3'd6: return 256;
         3'd7: return 1024;
         default: return 0;
      endcase
   endfunction

   function automatic bit model_tick(input logic [2:0] cs, input logic [9:0] psc);
      int n;
      n = divisor(cs);
      if (n == 0) return 1'b0;
      return ((int'(psc) % n) == n - 1);
   endfunction

   always @(posedge sys_clk) begin
      if (!async_phase) begin
         if (rst) begin
            m_p1 <= '0; m_p2 <= '0;
            m_t1 <= 1'b0; m_t2 <= 1'b0; m_t3 <= 1'b0;
            m_psc <= '0; m_cnt <= '0; m_oc <= 1'b0;
         end else begin
            automatic logic [2:0] cs   = m_p2[13:11];
            automatic logic       ctc  = m_p2[10];
            automatic logic [1:0] md   = m_p2[9:8];
            automatic logic [7:0] cv   = m_p2[7:0];
            automatic bit         tk   = model_tick(cs, m_psc) && !m_t3;
            automatic bit         hit  = tk && (m_cnt == cv);
            m_p1 <= {clk_sel, ctc_mode, cmp_mode, cmp_val};
            m_p2 <= m_p1;
            m_t1 <= psc_reset; m_t2 <= m_t1; m_t3 <= m_t2;
            m_psc <= m_t3 ? 10'd0 : m_psc + 10'd1;
            if (tk) m_cnt <= (ctc && hit) ? 8'd0 : m_cnt + 8'd1;
            if (hit) begin
               case (md)
                  2'b01: m_oc <= ~m_oc;
                  2'b10: m_oc <= 1'b0;
                  2'b11: m_oc <= 1'b1;
                  default: ;
               endcase
            end
         end
      end
   end

   task automatic check(input string tag, input int act, input int exp, input string what);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic step(input string tag);
      logic exp_pin;
      @(negedge sys_clk);
      exp_pin = (m_p2[9:8] != 2'b00) ? m_oc : port_val;
      check(tag, count_o, m_cnt, "count");
      check(tag, pin_out, exp_pin, "pin_out");
      check(tag, pin_oe, dir_en, "pin_oe");
   endtask

   task automatic run(input int n, input string tag);
      for (int i = 0; i < n; i++) step(tag);
   endtask

   task automatic strobe(input string tag);
      psc_reset = 1'b1;
      step(tag);
      psc_reset = 1'b0;
   endtask

   // ---------------- watchdog ----------------
   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   // ---------------- stimulus ----------------
   initial begin
      int unsigned seed;
      int a, b;
      seed = 32'd20240611;
      void'($urandom(seed));

      // R1: reset state
      rst = 1'b1;
      port_val = 1'b1;
      run(4, "R1");
      rst = 1'b0;
      run(4, "R1");
      port_val = 1'b0;
      run(2, "R1");

      // R2: stopped select keeps the count
      clk_sel = 3'd0; cmp_mode = 2'b01;
      run(20, "R2");

      // R9: undivided select after the sync delay
      clk_sel = 3'd1;
      run(6, "R9");

      // R4: free wrap through 255
      ctc_mode = 1'b0; cmp_mode = 2'b00; dir_en = 1'b1;
      run(300, "R4");

      // R5 / R6: clear-on-compare with toggle, then clear, then set
      cmp_val = 8'd5; ctc_mode = 1'b1; cmp_mode = 2'b01;
      run(40, "R5 R6");
      cmp_mode = 2'b11;
      run(20, "R6");
      cmp_mode = 2'b10;
      run(20, "R6");
      cmp_val = 8'd0;
      cmp_mode = 2'b01;
      run(20, "R5 R6");

      // R7 / R8: compare unit off, pin follows the port
      cmp_mode = 2'b00;
      for (int i = 0; i < 20; i++) begin
         port_val = i[0];
         dir_en = i[1];
         step("R7 R8");
      end

      // R2 / R3: divided ticks and prescaler clear
      cmp_mode = 2'b01; ctc_mode = 1'b0; clk_sel = 3'd2;
      run(50, "R2");
      strobe("R3");
      run(30, "R3");
      clk_sel = 3'd3;
      run(17, "R3");
      strobe("R3");
      run(80, "R3");

      // constrained random segments
      for (int seg = 0; seg < 150; seg++) begin
         automatic int pick = $urandom_range(0, 9);
         clk_sel  = (pick < 5) ? 3'd1 : (pick < 8) ? 3'd2 : 3'($urandom_range(0, 7));
         ctc_mode = 1'($urandom_range(0, 1));
         cmp_mode = 2'($urandom_range(0, 3));
         cmp_val  = (ctc_mode) ? 8'($urandom_range(0, 40)) : 8'($urandom_range(0, 255));
         dir_en   = 1'($urandom_range(0, 1));
         port_val = 1'($urandom_range(0, 1));
         if ($urandom_range(0, 3) == 0) strobe("R3 random");
         run(int'($urandom_range(20, 80)), "R2 R6 random");
      end

      // R10: asynchronous timer clock
      async_phase = 1'b1;
      rst = 1'b1;
      use_async = 1'b1;
      clk_sel = 3'd0; ctc_mode = 1'b0; cmp_mode = 2'b00;
      repeat (40) @(negedge sys_clk);
      rst = 1'b0;
      @(negedge sys_clk);
      clk_sel = 3'd1;
      repeat (10) @(negedge async_clk);
      a = count_o;
      repeat (20) @(negedge async_clk);
      b = count_o;
      check("R10", (b - a) & 8'hFF, 20, "async count delta");
      repeat (25) @(negedge async_clk);
      a = count_o;
      repeat (50) @(negedge async_clk);
      b = count_o;
      check("R10", (b - a) & 8'hFF, 50, "async count delta");
      clk_sel = 3'd0;
      repeat (10) @(negedge async_clk);
      a = count_o;
      repeat (30) @(negedge sys_clk);
      check("R10", count_o, a, "async stopped count");

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule